// File: doc/BRIEF.md
# Deferred-Fault Tagged Register File

This block is an integer register file in which every entry holds a data word and a one-bit fault tag. The tag lets a pipeline execute instructions ahead of the branches that guard them. When a speculative instruction faults, nothing traps. The destination is written with its tag set, and the fault waits in the register until something actually needs the value.

One operation is presented per cycle. It names two sources, each with its own use flag, and an optional destination. It also carries a speculative flag and a fault flag from the execution unit. A speculative operation passes the tag on: its result is tagged if it faulted or if any source it used was tagged. A non-speculative operation that uses a tagged source is refused. It writes nothing, and the block raises an exception naming the register. A separate check request probes one register and raises the same exception if that register is tagged. The exception appears one cycle after the request, as a single-cycle pulse with the offending register index.

Top module: `poison_rf`

## Requirements
- R1: Both read ports return the addressed entry's data and tag in the same cycle they are addressed, and show the state before any write made in that cycle.
- R2: A speculative operation with a fault, and with a write to a nonzero destination, stores the data with the tag set. It never raises an exception.
- R3: A speculative operation that uses a tagged source (a source whose use flag is high) writes its result with the tag set, and raises no exception.
- R4: A write with no fault and no tagged used source stores the data and clears the destination tag.
- R5: A non-speculative operation that uses a tagged source writes nothing. The cycle after, it pulses the exception output with the index of that source. Source A wins when both sources are tagged. Sources whose use flag is low are ignored.
- R6: A non-speculative operation with the fault flag high and no tagged used source writes nothing and raises no exception.
- R7: A check request on a tagged register pulses the exception output in the next cycle with that register's index. A check on a clean register has no effect. An exception from the operation in the same cycle takes priority over the check.
- R8: Register 0 always reads as data 0 with a clear tag. Writes to it are ignored.
- R9: The exception output is high only in a cycle that follows a triggering request. The exception index output is 0 whenever the exception output is low.
- R10: Reset clears every tag and every data word, and holds the exception output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_spec_i | input | 1 | Operation is speculative |
| op_fault_i | input | 1 | Operation faulted in execution |
| src_a_i | input | 7 | Source A register index |
| use_a_i | input | 1 | Operation consumes source A |
| src_b_i | input | 7 | Source B register index |
| use_b_i | input | 1 | Operation consumes source B |
| op_wr_i | input | 1 | Operation writes a destination |
| dst_i | input | 7 | Destination register index |
| wr_data_i | input | 64 | Result data |
| rd_a_data_o | output | 64 | Source A data |
| rd_a_poison_o | output | 1 | Source A fault tag |
| rd_b_data_o | output | 64 | Source B data |
| rd_b_poison_o | output | 1 | Source B fault tag |
| chk_i | input | 1 | Check request |
| chk_reg_i | input | 7 | Register to check |
| exc_o | output | 1 | Deferred exception pulse |
| exc_reg_o | output | 7 | Index of offending register |

## Verification
The embedded assertions watch, on every cycle, that speculative operations never lead to an exception, that a non-speculative use of a tagged source A produces the pulse with the right index, that a speculative fault lands in the destination tag, that a clean check stays silent, and that register 0 reads clean. The bench shows what the assertions cannot. It covers tag propagation through chains of dependent speculative operations, clearing by later clean writes, suppressed destinations seen by reading them back, and the priority between source A, source B and the check. A random run over a small set of registers compares every port against a behavioural model on each cycle.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;
  localparam int unsigned DEF_DATA_W   = 64;
  localparam int unsigned DEF_NUM_REGS = 128;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_SRC_A = 2'd1,
    EXC_SRC_B = 2'd2,
    EXC_CHK   = 2'd3
  } exc_src_e;
endpackage

// File: rtl/poison_rf_array.sv
module poison_rf_array #(
  parameter int unsigned DATA_W   = poison_rf_pkg::DEF_DATA_W,
  parameter int unsigned NUM_REGS = poison_rf_pkg::DEF_NUM_REGS,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     raddr_a_i,
  input  logic [AW-1:0]     raddr_b_i,
  input  logic [AW-1:0]     raddr_c_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic              rpois_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic              rpois_b_o,
  output logic              rpois_c_o,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wpois_i
);
  logic [DATA_W-1:0] data_q [NUM_REGS];
  logic              pois_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      // entry 0 is hardwired clean zero
      assign data_q[i] = '0;
      assign pois_q[i] = 1'b0;
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          data_q[i] <= '0;
          pois_q[i] <= 1'b0;
        end else if (we_i && waddr_i == AW'(i)) begin
          data_q[i] <= wdata_i;
          pois_q[i] <= wpois_i;
        end
      end
    end
  end

  assign rdata_a_o = data_q[raddr_a_i];
  assign rpois_a_o = pois_q[raddr_a_i];
  assign rdata_b_o = data_q[raddr_b_i];
  assign rpois_b_o = pois_q[raddr_b_i];
  assign rpois_c_o = pois_q[raddr_c_i];

  // R8
  zero_reg_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0 && !rpois_a_o));
endmodule

// File: rtl/poison_rf_ctrl.sv
module poison_rf_ctrl
  import poison_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = poison_rf_pkg::DEF_NUM_REGS,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic          op_valid_i,
  input  logic          op_spec_i,
  input  logic          op_fault_i,
  input  logic          use_a_i,
  input  logic          use_b_i,
  input  logic          op_wr_i,
  input  logic [AW-1:0] src_a_i,
  input  logic [AW-1:0] src_b_i,
  input  logic [AW-1:0] dst_i,
  input  logic          pois_a_i,
  input  logic          pois_b_i,
  input  logic          chk_i,
  input  logic [AW-1:0] chk_reg_i,
  input  logic          pois_c_i,
  output logic          we_o,
  output logic          wpois_o,
  output logic          exc_req_o,
  output logic [AW-1:0] exc_idx_o
);
  logic     tag_a, tag_b, src_tagged;
  exc_src_e exc_src;

  assign tag_a      = use_a_i && pois_a_i;
  assign tag_b      = use_b_i && pois_b_i;
  assign src_tagged = tag_a || tag_b;

  always_comb begin
    exc_src = EXC_NONE;
    if (op_valid_i && !op_spec_i && tag_a)      exc_src = EXC_SRC_A;
    else if (op_valid_i && !op_spec_i && tag_b) exc_src = EXC_SRC_B;
    else if (chk_i && pois_c_i)                 exc_src = EXC_CHK;
  end

  always_comb begin
    unique case (exc_src)
      EXC_SRC_A: exc_idx_o = src_a_i;
      EXC_SRC_B: exc_idx_o = src_b_i;
      EXC_CHK:   exc_idx_o = chk_reg_i;
      default:   exc_idx_o = '0;
    endcase
  end

  assign exc_req_o = (exc_src != EXC_NONE);

  // non-speculative: suppress on fault or tagged source
  assign we_o    = op_valid_i && op_wr_i && (dst_i != '0) &&
                   (op_spec_i || (!op_fault_i && !src_tagged));
  assign wpois_o = op_spec_i && (op_fault_i || src_tagged);
endmodule

// File: rtl/poison_rf.sv
module poison_rf
  import poison_rf_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_spec_i,
  input  logic              op_fault_i,
  input  logic [AW-1:0]     src_a_i,
  input  logic              use_a_i,
  input  logic [AW-1:0]     src_b_i,
  input  logic              use_b_i,
  input  logic              op_wr_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic              rd_a_poison_o,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic              rd_b_poison_o,
  input  logic              chk_i,
  input  logic [AW-1:0]     chk_reg_i,
  output logic              exc_o,
  output logic [AW-1:0]     exc_reg_o
);
  logic          we, wpois, pois_c, exc_req;
  logic [AW-1:0] exc_idx;

  poison_rf_array #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_array (
    .clk_i, .rst_ni,
    .raddr_a_i(src_a_i), .raddr_b_i(src_b_i), .raddr_c_i(chk_reg_i),
    .rdata_a_o(rd_a_data_o), .rpois_a_o(rd_a_poison_o),
    .rdata_b_o(rd_b_data_o), .rpois_b_o(rd_b_poison_o),
    .rpois_c_o(pois_c),
    .we_i(we), .waddr_i(dst_i), .wdata_i(wr_data_i), .wpois_i(wpois)
  );

  poison_rf_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .op_valid_i, .op_spec_i, .op_fault_i, .use_a_i, .use_b_i, .op_wr_i,
    .src_a_i, .src_b_i, .dst_i,
    .pois_a_i(rd_a_poison_o), .pois_b_i(rd_b_poison_o),
    .chk_i, .chk_reg_i, .pois_c_i(pois_c),
    .we_o(we), .wpois_o(wpois), .exc_req_o(exc_req), .exc_idx_o(exc_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o     <= 1'b0;
      exc_reg_o <= '0;
    end else begin
      exc_o     <= exc_req;
      exc_reg_o <= exc_req ? exc_idx : '0;
    end
  end

  // R2
  spec_no_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_spec_i && !chk_i) |=> !exc_o);

  // R5
  nonspec_use_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_spec_i && use_a_i && rd_a_poison_o)
      |=> (exc_o && exc_reg_o == $past(src_a_i)));

  // R2
  spec_fault_tags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_spec_i && op_fault_i && op_wr_i && dst_i != '0)
      |=> u_array.pois_q[$past(dst_i)]);

  // R7
  clean_chk_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && chk_i && !pois_c) |=> !exc_o);

  // R9
  idle_idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> exc_reg_o == '0);
endmodule

// File: tb/poison_rf_tb.sv
module poison_rf_tb;
  localparam int NR = 128;
  localparam int AW = 7;

  logic clk = 0, rst_ni = 0;
  logic op_valid = 0, op_spec = 0, op_fault = 0, use_a = 0, use_b = 0, op_wr = 0, chk = 0;
  logic [AW-1:0] src_a = 0, src_b = 0, dst = 0, chk_reg = 0;
  logic [63:0] wr_data = 0;
  logic [63:0] rd_a_data, rd_b_data;
  logic rd_a_p, rd_b_p, exc;
  logic [AW-1:0] exc_reg;

  int n_run = 0, n_fail = 0;
  logic [63:0] m_data [NR];
  bit          m_pois [NR];

  always #5 clk = ~clk;

  poison_rf u_dut (
    .clk_i(clk), .rst_ni, .op_valid_i(op_valid), .op_spec_i(op_spec), .op_fault_i(op_fault),
    .src_a_i(src_a), .use_a_i(use_a), .src_b_i(src_b), .use_b_i(use_b), .op_wr_i(op_wr),
    .dst_i(dst), .wr_data_i(wr_data), .rd_a_data_o(rd_a_data), .rd_a_poison_o(rd_a_p),
    .rd_b_data_o(rd_b_data), .rd_b_poison_o(rd_b_p), .chk_i(chk), .chk_reg_i(chk_reg),
    .exc_o(exc), .exc_reg_o(exc_reg)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: inputs applied at negedge, reads checked, exception checked after the edge
  task automatic cyc(bit v, bit sp, bit f, int a, bit ua, int b, bit ub, bit w, int d,
                     logic [63:0] wd, bit c, int cr, string req);
    bit ta, tb, e_exc, we, wp;
    int e_idx;
    op_valid = v; op_spec = sp; op_fault = f; src_a = AW'(a); use_a = ua;
    src_b = AW'(b); use_b = ub; op_wr = w; dst = AW'(d); wr_data = wd; chk = c; chk_reg = AW'(cr);
    #1;
    check({req, " R1 rd_a data"}, rd_a_data, m_data[a]);
    check({req, " R1 rd_a tag"}, 64'(rd_a_p), 64'(m_pois[a]));
    check({req, " R1 rd_b data"}, rd_b_data, m_data[b]);
    check({req, " R1 rd_b tag"}, 64'(rd_b_p), 64'(m_pois[b]));
    ta = ua && m_pois[a]; tb = ub && m_pois[b];
    e_exc = 0; e_idx = 0;
    if (v && !sp && ta) begin e_exc = 1; e_idx = a; end
    else if (v && !sp && tb) begin e_exc = 1; e_idx = b; end
    else if (c && m_pois[cr]) begin e_exc = 1; e_idx = cr; end
    we = v && w && d != 0 && (sp || (!f && !ta && !tb));
    wp = sp && (f || ta || tb);
    @(posedge clk);
    if (we) begin m_data[d] = wd; m_pois[d] = wp; end
    #1;
    check({req, " R9 exc"}, 64'(exc), 64'(e_exc));
    check({req, " R9 exc idx"}, 64'(exc_reg), 64'(e_idx));
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0,0,0,0,0,0,0,0,0,0,0,0,"idle");
  endtask

  // read back register r on port A with no op
  task automatic peek(int r, string req);
    cyc(0,0,0,r,0,r,0,0,0,0,0,0,req);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin m_data[i] = 0; m_pois[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check("R10 exc after reset", 64'(exc), 0);
    rst_ni = 1;
    @(negedge clk);
    peek(5, "R10 reset clear");
    peek(127, "R10 reset clear hi");
    // R4 clean writes
    cyc(1,0,0,0,0,0,0,1,3,64'hA5A5,0,0,"R4 write r3");
    cyc(1,1,0,0,0,0,0,1,4,64'h1234,0,0,"R4 spec clean r4");
    peek(3, "R4 read r3");
    // R2 speculative fault
    cyc(1,1,1,3,1,4,1,1,6,64'hDEAD,0,0,"R2 spec fault r6");
    peek(6, "R2 r6 tagged");
    // R3 propagation chain
    cyc(1,1,0,6,1,3,1,1,7,64'h77,0,0,"R3 prop r7");
    cyc(1,1,0,3,1,7,1,1,8,64'h88,0,0,"R3 prop src b r8");
    cyc(1,1,0,6,0,3,1,1,9,64'h99,0,0,"R3 unused tag r9 clean");
    peek(8, "R3 r8 tagged");
    // R5 non-spec use: src A, src B, both, unused
    cyc(1,0,0,6,1,3,1,1,10,64'h10,0,0,"R5 src A tag");
    peek(10, "R5 r10 unwritten");
    cyc(1,0,0,3,1,7,1,1,10,64'h11,0,0,"R5 src B tag");
    cyc(1,0,0,7,1,6,1,1,10,64'h12,0,0,"R5 both prio A");
    cyc(1,0,0,6,0,7,0,1,10,64'h13,0,0,"R5 unused sources");
    peek(10, "R5 r10 written");
    // R6 non-spec fault
    cyc(1,0,1,3,1,4,1,1,11,64'h55,0,0,"R6 nonspec fault");
    peek(11, "R6 r11 unwritten");
    // R7 checks
    cyc(0,0,0,0,0,0,0,0,0,0,1,6,"R7 chk tagged");
    cyc(0,0,0,0,0,0,0,0,0,0,1,3,"R7 chk clean");
    cyc(1,0,0,7,1,0,0,0,0,0,1,6,"R7 op over chk");
    cyc(1,1,0,0,0,0,0,1,12,64'h1,1,8,"R7 chk with spec op");
    // R4 clean write clears tag
    cyc(1,0,0,3,1,0,0,1,6,64'hC1EA,0,0,"R4 clear r6");
    cyc(0,0,0,0,0,0,0,0,0,0,1,6,"R4 chk after clear");
    // R8 register 0
    cyc(1,0,0,0,0,0,0,1,0,64'hFFFF,0,0,"R8 write r0");
    cyc(1,1,1,0,0,0,0,1,0,64'hFFFF,0,0,"R8 spec fault r0");
    cyc(0,0,0,0,0,0,0,0,0,0,1,0,"R8 chk r0");
    peek(0, "R8 r0 zero");
    // random traffic over r0..r7 plus high regs
    for (int k = 0; k < 600; k++) begin
      int a, b, d, cr;
      a = $urandom_range(0,7); b = $urandom_range(0,7);
      d = ($urandom_range(0,9) == 0) ? 127 : $urandom_range(0,7);
      cr = $urandom_range(0,7);
      cyc($urandom_range(0,3) != 0, $urandom_range(0,1), $urandom_range(0,3) == 0,
          a, $urandom_range(0,1), b, $urandom_range(0,1), $urandom_range(0,3) != 0, d,
          {$urandom, $urandom}, $urandom_range(0,2) == 0, cr, "R3 R5 R7 random");
    end
    idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule